// File: doc/BRIEF.md
# Command-Sequenced Flash Memory Controller

This block models a small byte-addressable nonvolatile store behind a simple bus slave port. Reads return stored bytes one cycle after the read strobe. Writes never reach the array directly. Each write is fed to a command sequencer. The sequencer only accepts an operation after a fixed two-write unlock handshake on two key addresses. The operations it accepts are reset, identification mode, byte program, whole-array erase, and erase of one sector. Sector erase can be suspended and resumed.

Program and erase operations each last a parameterised number of clock ticks. While one runs, the `busy` output is high. Reads in that time return a status byte whose bit 6 flips on every read, not array data. Storage is a register array of `MEM_BYTES` bytes split into `NUM_SECTORS` equal sectors. Both counts must be powers of two, so read and program addresses wrap modulo the array size.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `rdata` is 0x00, and every byte of the array reads 0xFF.
- R2: A read strobe with `busy` low and identification mode off loads `rdata` on the same clock edge with the byte at index `addr mod MEM_BYTES`.
- R3: Unlocking takes two writes: data 0xAA to address 0x5555, then data 0x55 to address 0x2AAA. Any other write in the second slot returns the sequencer to read mode, and a command write that follows has no effect.
- R4: After unlock, a write of 0xA0 to 0x5555 arms byte program. The next write stores (old AND new) at its address, so a bit can be cleared but never set.
- R5: A byte program holds `busy` high for exactly `PROG_TICKS` cycles after the data write, and then the sequencer returns to read mode.
- R6: Each read strobe while `busy` is high returns a status byte with all bits except bit 6 at zero. Bit 6 is 0 on the first such read of an operation and inverts on each later one.
- R7: After unlock, a write of 0xF0 to 0x5555 returns to read mode, and the next data write does not program.
- R8: After unlock, a write of 0x90 to 0x5555 enters identification mode, in which reads return `ID_BYTE`. In that mode, 0xF0 returns to read mode and 0xAA written to 0x5555 counts as the first unlock write.
- R9: Erase setup is unlock, then 0x80 to 0x5555, then a second unlock. If the write after that is 0x10 to 0x5555, every byte becomes 0xFF after `ERASE_TICKS` busy cycles.
- R10: Any other write in that slot erases only the sector holding its address (sector = index / (`MEM_BYTES`/`NUM_SECTORS`)). The sector becomes 0xFF after `SECT_START_TICKS` + `ERASE_TICKS` busy cycles, and other sectors keep their contents.
- R11: During a sector erase, data 0xB0 suspends it: `busy` drops, reads return the unerased array, and the countdown holds. Data 0x30 resumes it. Every other write in these states is ignored.
- R12: Writes made while a byte program or a whole-array erase runs are ignored, including unlock writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one command write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data / command code |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High while a program or erase is counting |

## Verification
The bench goes after partial unlocks. A sequencer that does not fall back to read mode would program a byte from a later stray write. Programming a byte twice shows whether a write can raise bits, which an array storing data directly would do. Writes during a busy period show whether the sequencer is locked, since an unlocked one would start a second program early. Sector erase is checked at the boundaries of each sector, and a suspend in the start delay must leave the data intact and keep the remaining time. A wrong sector decode, or a countdown that keeps running, would erase the wrong bytes or finish early.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [3:0] {
      S_READ,
      S_UNL1,
      S_UNL2,
      S_ASEL,
      S_PGM,
      S_ERS1,
      S_ERS2,
      S_ERS3,
      S_PROGRAMMING,
      S_CHIP_ERASING,
      S_SECT_START,
      S_SECT_ERASING,
      S_SECT_SUSP
   } fl_state_e;

   localparam logic [15:0] KEY_ADDR_A = 16'h5555;
   localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

   localparam logic [7:0] CODE_KEY1    = 8'hAA;
   localparam logic [7:0] CODE_KEY2    = 8'h55;
   localparam logic [7:0] CODE_RESET   = 8'hF0;
   localparam logic [7:0] CODE_IDENT   = 8'h90;
   localparam logic [7:0] CODE_PROGRAM = 8'hA0;
   localparam logic [7:0] CODE_ERASE   = 8'h80;
   localparam logic [7:0] CODE_CHIP    = 8'h10;
   localparam logic [7:0] CODE_SUSPEND = 8'hB0;
   localparam logic [7:0] CODE_RESUME  = 8'h30;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter int IDX_W            = 6,
   parameter int SECT_W           = 2,
   parameter int PROG_TICKS       = 4,
   parameter int SECT_START_TICKS = 3,
   parameter int ERASE_TICKS      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              busy,
   output logic              asel,
   output logic              prog_go,
   output logic              chip_clr,
   output logic              sect_clr,
   output logic [SECT_W-1:0] sect_sel
);
   localparam int MAX_T = (PROG_TICKS > ERASE_TICKS)
                        ? ((PROG_TICKS > SECT_START_TICKS) ? PROG_TICKS : SECT_START_TICKS)
                        : ((ERASE_TICKS > SECT_START_TICKS) ? ERASE_TICKS : SECT_START_TICKS);
   localparam int CNT_W = $clog2(MAX_T + 1);

   fl_state_e         st, resume_st;
   logic [CNT_W-1:0]  cnt;
   logic              key_a, key_b, susp_req, resume_req;

   assign key_a      = (wr_addr == ADDR_W'(KEY_ADDR_A));
   assign key_b      = (wr_addr == ADDR_W'(KEY_ADDR_B));
   assign susp_req   = wr_en && (wr_data == CODE_SUSPEND);
   assign resume_req = wr_en && (wr_data == CODE_RESUME);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_READ;
         resume_st <= S_SECT_START;
         cnt       <= '0;
         sect_sel  <= '0;
      end else begin
         case (st)
            S_READ:
               if (wr_en && key_a && wr_data == CODE_KEY1) st <= S_UNL1;
            S_UNL1:
               if (wr_en) st <= (key_b && wr_data == CODE_KEY2) ? S_UNL2 : S_READ;
            S_UNL2:
               if (wr_en) begin
                  if (!key_a)                        st <= S_READ;
                  else if (wr_data == CODE_IDENT)    st <= S_ASEL;
                  else if (wr_data == CODE_PROGRAM)  st <= S_PGM;
                  else if (wr_data == CODE_ERASE)    st <= S_ERS1;
                  else                               st <= S_READ;
               end
            S_ASEL:
               if (wr_en) st <= (key_a && wr_data == CODE_KEY1) ? S_UNL1 : S_READ;
            S_PGM:
               if (wr_en) begin
                  st  <= S_PROGRAMMING;
                  cnt <= CNT_W'(PROG_TICKS - 1);
               end
            S_ERS1:
               if (wr_en) st <= (key_a && wr_data == CODE_KEY1) ? S_ERS2 : S_READ;
            S_ERS2:
               if (wr_en) st <= (key_b && wr_data == CODE_KEY2) ? S_ERS3 : S_READ;
            S_ERS3:
               if (wr_en) begin
                  if (key_a && wr_data == CODE_CHIP) begin
                     st  <= S_CHIP_ERASING;
                     cnt <= CNT_W'(ERASE_TICKS - 1);
                  end else begin
                     st       <= S_SECT_START;
                     cnt      <= CNT_W'(SECT_START_TICKS - 1);
                     sect_sel <= wr_addr[IDX_W-1:IDX_W-SECT_W];
                  end
               end
            S_PROGRAMMING, S_CHIP_ERASING:
               if (cnt == '0) st <= S_READ;
               else           cnt <= cnt - 1'b1;
            S_SECT_START:
               if (susp_req) begin
                  resume_st <= S_SECT_START;
                  st        <= S_SECT_SUSP;
               end else if (cnt == '0) begin
                  st  <= S_SECT_ERASING;
                  cnt <= CNT_W'(ERASE_TICKS - 1);
               end else cnt <= cnt - 1'b1;
            S_SECT_ERASING:
               if (susp_req) begin
                  resume_st <= S_SECT_ERASING;
                  st        <= S_SECT_SUSP;
               end else if (cnt == '0) st <= S_READ;
               else                    cnt <= cnt - 1'b1;
            S_SECT_SUSP:
               if (resume_req) st <= resume_st;
            default: st <= S_READ;
         endcase
      end
   end

   assign busy     = (st == S_PROGRAMMING) || (st == S_CHIP_ERASING) ||
                     (st == S_SECT_START)  || (st == S_SECT_ERASING);
   assign asel     = (st == S_ASEL);
   assign prog_go  = (st == S_PGM) && wr_en;
   assign chip_clr = (st == S_CHIP_ERASING) && (cnt == '0);
   assign sect_clr = (st == S_SECT_ERASING) && (cnt == '0) && !susp_req;

   AST_UNLOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_UNL1 && wr_en && !(key_b && wr_data == CODE_KEY2)) |=> (st == S_READ)); // R3
   AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_PROGRAMMING) |=> (st == S_PROGRAMMING || st == S_READ)); // R12
   AST_CHIP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_CHIP_ERASING) |=> (st == S_CHIP_ERASING || st == S_READ)); // R12
   AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SECT_SUSP) |=> $stable(cnt)); // R11
   AST_SUSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SECT_SUSP) |-> !busy && !sect_clr); // R11

endmodule

// File: rtl/flash_store.sv
module flash_store #(
   parameter int MEM_BYTES  = 64,
   parameter int IDX_W      = 6,
   parameter int SECT_W     = 2,
   parameter int SECT_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_go,
   input  logic [IDX_W-1:0]  prog_idx,
   input  logic [7:0]        prog_data,
   input  logic              chip_clr,
   input  logic              sect_clr,
   input  logic [SECT_W-1:0] sect_sel,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_byte
);
   logic [7:0] mem [MEM_BYTES];

   for (genvar i = 0; i < MEM_BYTES; i++) begin : g_cell
      localparam int CELL_SECT = i / SECT_BYTES;
      logic hit_sect;
      assign hit_sect = sect_clr && (sect_sel == SECT_W'(CELL_SECT));
      always_ff @(posedge clk) begin
         if (!rst_n)                                    mem[i] <= 8'hFF;
         else if (chip_clr || hit_sect)                 mem[i] <= 8'hFF;
         else if (prog_go && prog_idx == IDX_W'(i))     mem[i] <= mem[i] & prog_data;
      end
   end

   assign rd_byte = mem[rd_idx];

   AST_PROG_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go && !chip_clr && !sect_clr) |=>
      ((mem[$past(prog_idx)] & ~$past(mem[prog_idx])) == 8'h00)); // R4

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
   parameter int         ADDR_W           = 16,
   parameter int         MEM_BYTES        = 64,
   parameter int         NUM_SECTORS      = 4,
   parameter int         PROG_TICKS       = 4,
   parameter int         SECT_START_TICKS = 3,
   parameter int         ERASE_TICKS      = 8,
   parameter logic [7:0] ID_BYTE          = 8'hA7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              busy
);
   localparam int IDX_W      = $clog2(MEM_BYTES);
   localparam int SECT_W     = $clog2(NUM_SECTORS);
   localparam int SECT_BYTES = MEM_BYTES / NUM_SECTORS;

   if (ADDR_W < 15) begin : g_bad_addr
      $error("ADDR_W must reach the key addresses");
   end
   if ((1 << IDX_W) != MEM_BYTES || MEM_BYTES > (1 << ADDR_W)) begin : g_bad_size
      $error("MEM_BYTES must be a power of two within the address space");
   end
   if (NUM_SECTORS < 2 || SECT_BYTES * NUM_SECTORS != MEM_BYTES) begin : g_bad_sect
      $error("NUM_SECTORS must be at least 2 and divide MEM_BYTES exactly");
   end
   if (PROG_TICKS < 1 || SECT_START_TICKS < 1 || ERASE_TICKS < 1) begin : g_bad_ticks
      $error("tick counts must be at least 1");
   end

   logic              asel, prog_go, chip_clr, sect_clr, tog;
   logic [SECT_W-1:0] sect_sel;
   logic [7:0]        rd_byte;
   logic [IDX_W-1:0]  idx;

   assign idx = addr[IDX_W-1:0];

   flash_seq_fsm #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SECT_W(SECT_W),
      .PROG_TICKS(PROG_TICKS), .SECT_START_TICKS(SECT_START_TICKS),
      .ERASE_TICKS(ERASE_TICKS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
      .busy(busy), .asel(asel), .prog_go(prog_go), .chip_clr(chip_clr),
      .sect_clr(sect_clr), .sect_sel(sect_sel)
   );

   flash_store #(
      .MEM_BYTES(MEM_BYTES), .IDX_W(IDX_W), .SECT_W(SECT_W), .SECT_BYTES(SECT_BYTES)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_idx(idx), .prog_data(wdata),
      .chip_clr(chip_clr), .sect_clr(sect_clr), .sect_sel(sect_sel),
      .rd_idx(idx), .rd_byte(rd_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= 8'h00;
         tog   <= 1'b0;
      end else begin
         if (!busy)      tog <= 1'b0;
         else if (rd_en) tog <= ~tog;
         if (rd_en) begin
            if (busy)      rdata <= {1'b0, tog, 6'b0};
            else if (asel) rdata <= ID_BYTE;
            else           rdata <= rd_byte;
         end
      end
   end

   AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> ((rdata & 8'hBF) == 8'h00)); // R6
   AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && $past(rd_en && busy)) |=> (rdata[6] != $past(rdata[6]))); // R6

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int MEMB  = 32;
   localparam int NSECT = 4;
   localparam int SBYTES = MEMB / NSECT;
   localparam int PT = 3, ST = 2, ET = 4;
   localparam logic [7:0] IDB = 8'h5A;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic busy;
   logic [7:0] model [MEMB];
   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_ctrl #(.ADDR_W(16), .MEM_BYTES(MEMB), .NUM_SECTORS(NSECT),
      .PROG_TICKS(PT), .SECT_START_TICKS(ST), .ERASE_TICKS(ET), .ID_BYTE(IDB)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .busy(busy));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock();
      wr(16'h5555, 8'hAA);
      wr(16'h2AAA, 8'h55);
   endtask

   task automatic program_byte(input logic [15:0] a, input logic [7:0] d);
      unlock();
      wr(16'h5555, 8'hA0);
      wr(a, d);
      model[a % MEMB] = model[a % MEMB] & d;
      idle(PT);
   endtask

   task automatic erase_setup();
      unlock();
      wr(16'h5555, 8'h80);
      unlock();
   endtask

   task automatic sweep(input string req);
      logic [7:0] v;
      for (int i = 0; i < MEMB; i++) begin
         rd(16'(i), v);
         check(req, v, model[i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
      idle(3);
      // R1: reset state
      check("R1 rdata", rdata, 8'h00);
      check("R1 busy", {7'b0, busy}, 8'h00);
      rst_n = 1'b1;
      idle(1);
      sweep("R1 erased");

      // R2: address wrap
      rd(16'(MEMB + 5), v); check("R2 wrap", v, model[5]);

      // R4/R5/R6: program every byte, busy and status reads on one of them
      unlock(); wr(16'h5555, 8'hA0); wr(16'd7, 8'h3C);
      model[7] = 8'h3C;
      check("R5 busy high", {7'b0, busy}, 8'h01);
      rd(16'd7, v); check("R6 status first", v, 8'h00);
      rd(16'd7, v); check("R6 status second", v, 8'h40);
      idle(PT);
      check("R5 busy low", {7'b0, busy}, 8'h00);
      rd(16'd7, v); check("R4 programmed", v, 8'h3C);
      for (int i = 0; i < MEMB; i++) program_byte(16'(i), 8'((i * 37 + 5) & 8'hFF));
      sweep("R4 first pass");
      for (int i = 0; i < MEMB; i++) program_byte(16'(i + MEMB), ~8'((i * 11) & 8'hFF));
      sweep("R4 and pass");
      program_byte(16'd3, 8'hFF);
      rd(16'd3, v); check("R4 no set", v, model[3]);

      // R5: busy lasts exactly PT cycles
      unlock(); wr(16'h5555, 8'hA0); wr(16'd1, 8'hFF);
      idle(PT - 1);
      check("R5 busy at end-1", {7'b0, busy}, 8'h01);
      idle(1);
      check("R5 busy after", {7'b0, busy}, 8'h00);

      // R3: broken unlock then stray command
      wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'd9, 8'h00);
      rd(16'd9, v); check("R3 bad addr", v, model[9]);
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54); wr(16'h5555, 8'hA0); wr(16'd9, 8'h00);
      rd(16'd9, v); check("R3 bad data", v, model[9]);

      // R7: reset command
      unlock(); wr(16'h5555, 8'hF0); wr(16'd10, 8'h00);
      rd(16'd10, v); check("R7 reset cmd", v, model[10]);

      // R8: identification mode
      unlock(); wr(16'h5555, 8'h90);
      rd(16'd4, v); check("R8 id", v, IDB);
      wr(16'h0000, 8'hF0);
      rd(16'd4, v); check("R8 exit", v, model[4]);
      unlock(); wr(16'h5555, 8'h90);
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'd12, 8'h0F);
      model[12] = model[12] & 8'h0F;
      idle(PT);
      rd(16'd12, v); check("R8 relock", v, model[12]);

      // R12: writes during program ignored
      unlock(); wr(16'h5555, 8'hA0); wr(16'd2, 8'hFE);
      model[2] = model[2] & 8'hFE;
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'd9, 8'h00);
      idle(2);
      rd(16'd9, v); check("R12 ignored", v, model[9]);
      rd(16'd2, v); check("R12 program kept", v, model[2]);

      // R10: sector erase of sector 2 via addr 17
      erase_setup(); wr(16'd17, 8'h30);
      check("R10 busy", {7'b0, busy}, 8'h01);
      idle(ST + ET - 1);
      check("R10 busy end-1", {7'b0, busy}, 8'h01);
      idle(1);
      check("R10 done", {7'b0, busy}, 8'h00);
      for (int i = 2 * SBYTES; i < 3 * SBYTES; i++) model[i] = 8'hFF;
      sweep("R10 sector");

      // R11: suspend during start delay of sector 0, resume
      for (int i = 0; i < SBYTES; i++) program_byte(16'(i), 8'h00);
      erase_setup(); wr(16'd5, 8'h44);
      wr(16'd0, 8'hB0);
      check("R11 suspended busy", {7'b0, busy}, 8'h00);
      rd(16'd0, v); check("R11 data kept", v, 8'h00);
      wr(16'd0, 8'h55); wr(16'h5555, 8'hAA);
      idle(ST + ET + 2);
      rd(16'd7, v); check("R11 still suspended", v, 8'h00);
      wr(16'd0, 8'h30);
      check("R11 resumed busy", {7'b0, busy}, 8'h01);
      wr(16'd0, 8'h12);
      idle(ST + ET);
      check("R11 finished", {7'b0, busy}, 8'h00);
      for (int i = 0; i < SBYTES; i++) model[i] = 8'hFF;
      sweep("R11 erased");

      // R11: suspend during erasing phase of sector 3
      for (int i = 3 * SBYTES; i < 4 * SBYTES; i++) program_byte(16'(i), 8'h81);
      erase_setup(); wr(16'd30, 8'h00);
      idle(ST + 1);
      wr(16'd0, 8'hB0);
      rd(16'd30, v); check("R11 mid suspend", v, model[30]);
      wr(16'd0, 8'h30);
      idle(ET);
      for (int i = 3 * SBYTES; i < 4 * SBYTES; i++) model[i] = 8'hFF;
      sweep("R11 mid resume");

      // R9: chip erase
      erase_setup(); wr(16'h5555, 8'h10);
      wr(16'h5555, 8'hAA);
      idle(ET - 2);
      check("R9 busy", {7'b0, busy}, 8'h01);
      idle(1);
      check("R9 done", {7'b0, busy}, 8'h00);
      for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
      sweep("R9 chip");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule